// File: doc/BRIEF.md
# Steerable Interrupt Aggregator

This block collects up to 32 interrupt request lines and presents them to a processor as two interrupt outputs, `int0_o` and `int1_o`. Each source is brought into the clock domain through a two-flop synchroniser. A per-source polarity bit can invert the line, and a per-source mode bit selects level or rising-edge detection. A per-source steering bit routes the source to one of the two outputs. The four lowest sources are general-purpose pin inputs, and each of them has an extra input-enable gate.

Software controls the block through a small word-addressed register bus. Enables are never written directly. A set register turns bits on and a clear register turns them off, so one driver can change its own source without a read-modify-write race against another driver. A status register and an enable register can both be read, and software ANDs them to find the sources it should service. Device interrupts normally run as level sources on output 0. Error strobes normally run as edge sources on output 1.

Top module: `steer_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and both `int0_o` and `int1_o` are low.
- R2: A write to word 2 sets each enable bit whose data bit is 1. Bits written 0 keep their value. Word 1 reads the current enable vector.
- R3: A write to word 3 clears each enable bit whose data bit is 1. Bits written 0 keep their value.
- R4: Word 4 holds a per-source invert bit. When the bit is 1, a low input counts as active.
- R5: A source whose mode bit is 0 is level-sensitive. Its bit in the status register (word 0) follows the corrected input after two synchronising clocks, and the output reflects it one clock later.
- R6: A source whose mode bit (word 5) is 1 is edge-sensitive. It latches pending on a rising edge of the corrected input and stays pending after the input falls. Writing 1 to its status bit clears it, and writing 0 leaves it set.
- R7: When a clear of a pending bit (a write of 1 to its status bit) lands in the same cycle as a new rising edge, the edge wins and the bit stays set.
- R8: Steering bits are held in word 6. A source with steering bit 0 drives `int0_o`, and a source with steering bit 1 drives `int1_o`.
- R9: Each output is a registered OR of the sources that are pending, enabled and steered to it. A pending source that is disabled asserts neither output.
- R10: Word 7 holds input-enable bits for sources 0 to 3 only, and its upper bits read 0. A pin source whose input-enable bit is 0 never shows pending.
- R11: Read data appears on `rdata_o` in the cycle after the read request. Addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Raw interrupt lines, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read |
| int0_o | output | 1 | Processor interrupt line 0 |
| int1_o | output | 1 | Processor interrupt line 1 |

## Verification
The hardest case to reach is the race in which software clears an edge-pending bit in the same cycle that a new rising edge is detected. A line change takes two synchroniser clocks, plus one clock for the edge compare, before it reaches the pending flop. The bench therefore drives the line and then issues the status write exactly two falling edges later, so that the write lands on the clock edge where the new edge latches. It then reads status back to confirm that the bit survived.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_STAT    = 4'd0,
    REG_EN      = 4'd1,
    REG_EN_SET  = 4'd2,
    REG_EN_CLR  = 4'd3,
    REG_POL     = 4'd4,
    REG_EDGE    = 4'd5,
    REG_STEER   = 4'd6,
    REG_GPIO_IE = 4'd7
  } reg_idx_e;
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_GPIO = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  edge_o,
  output logic [N_SRC-1:0]  steer_o,
  output logic [N_GPIO-1:0] gpio_ie_o,
  output logic [N_SRC-1:0]  clr_pend_o,
  output logic [N_SRC-1:0]  rdata_o
);
  localparam int PAD = N_SRC - N_GPIO;

  logic              wr, rd;
  logic [N_SRC-1:0]  set_m, clr_m, rd_mux;
  logic [N_SRC-1:0]  en_q, pol_q, edge_q, steer_q, rdata_q;
  logic [N_GPIO-1:0] ie_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign set_m      = (wr && addr_i == REG_EN_SET) ? wdata_i : '0;
  assign clr_m      = (wr && addr_i == REG_EN_CLR) ? wdata_i : '0;
  assign clr_pend_o = (wr && addr_i == REG_STAT)   ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      steer_q <= '0;
      ie_q    <= '0;
    end else begin
      en_q <= (en_q | set_m) & ~clr_m;
      if (wr) begin
        case (addr_i)
          REG_POL:     pol_q   <= wdata_i;
          REG_EDGE:    edge_q  <= wdata_i;
          REG_STEER:   steer_q <= wdata_i;
          REG_GPIO_IE: ie_q    <= wdata_i[N_GPIO-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      REG_STAT:    rd_mux = status_i;
      REG_EN:      rd_mux = en_q;
      REG_POL:     rd_mux = pol_q;
      REG_EDGE:    rd_mux = edge_q;
      REG_STEER:   rd_mux = steer_q;
      REG_GPIO_IE: rd_mux = {{PAD{1'b0}}, ie_q};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign en_o      = en_q;
  assign pol_o     = pol_q;
  assign edge_o    = edge_q;
  assign steer_o   = steer_q;
  assign gpio_ie_o = ie_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/sic_detect.sv
module sic_detect #(
  parameter int N_SRC  = 32,
  parameter int N_GPIO = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  sync_i,
  input  logic [N_SRC-1:0]  pol_i,
  input  logic [N_SRC-1:0]  edge_i,
  input  logic [N_GPIO-1:0] gpio_ie_i,
  input  logic [N_SRC-1:0]  clr_pend_i,
  output logic [N_SRC-1:0]  status_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic gate, act, act_q, rise, pend_q;

    if (i < N_GPIO) begin : g_pin
      assign gate = gpio_ie_i[i];
    end else begin : g_dev
      assign gate = 1'b1;
    end

    assign act  = (sync_i[i] ^ pol_i[i]) & gate;
    assign rise = act & ~act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        act_q <= act;
        // a fresh edge beats a concurrent software clear
        if (rise && edge_i[i])  pend_q <= 1'b1;
        else if (clr_pend_i[i]) pend_q <= 1'b0;
      end
    end

    assign status_o[i] = (edge_i[i] ? pend_q : act) & gate;
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] steer_i,
  output logic             int0_o,
  output logic             int1_o
);
  logic [N_SRC-1:0] live;
  logic             int0_q, int1_q;

  assign live = status_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int0_q <= 1'b0;
      int1_q <= 1'b0;
    end else begin
      int0_q <= |(live & ~steer_i);
      int1_q <= |(live & steer_i);
    end
  end

  assign int0_o = int0_q;
  assign int1_o = int1_q;
endmodule

// File: rtl/steer_irq_ctrl.sv
module steer_irq_ctrl
  import sic_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int N_GPIO   = 4,
  parameter int N_SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              int0_o,
  output logic              int1_o
);
  logic [N_SRC-1:0]  sync, en, pol, edge_m, steer, clr_pend, status;
  logic [N_GPIO-1:0] gpio_ie;

  sic_sync #(.W(N_SRC), .STAGES(N_SYNC)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (irq_i), .q_o (sync)
  );

  sic_regs #(.N_SRC(N_SRC), .N_GPIO(N_GPIO)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_i   (status),
    .en_o       (en),
    .pol_o      (pol),
    .edge_o     (edge_m),
    .steer_o    (steer),
    .gpio_ie_o  (gpio_ie),
    .clr_pend_o (clr_pend),
    .rdata_o    (rdata_o)
  );

  sic_detect #(.N_SRC(N_SRC), .N_GPIO(N_GPIO)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync),
    .pol_i      (pol),
    .edge_i     (edge_m),
    .gpio_ie_i  (gpio_ie),
    .clr_pend_i (clr_pend),
    .status_o   (status)
  );

  sic_route #(.N_SRC(N_SRC)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status),
    .en_i     (en),
    .steer_i  (steer),
    .int0_o   (int0_o),
    .int1_o   (int1_o)
  );
endmodule

// File: rtl/sic_chk.sv
module sic_chk
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_GPIO = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic [N_SRC-1:0]  en_i,
  input logic [N_SRC-1:0]  steer_i,
  input logic [N_SRC-1:0]  status_i,
  input logic [N_GPIO-1:0] gpio_ie_i,
  input logic              int0_i,
  input logic              int1_i
);
  logic set_wr, clr_wr;
  assign set_wr = req_i && we_i && addr_i == REG_EN_SET;
  assign clr_wr = req_i && we_i && addr_i == REG_EN_CLR;

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> en_i == ($past(en_i) | $past(wdata_i)));

  a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> en_i == ($past(en_i) & ~$past(wdata_i)));

  a_r2_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_wr || clr_wr) |=> $stable(en_i));

  a_r8_int0_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & en_i & ~steer_i)) |=> int0_i);

  a_r8_int1_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & en_i & steer_i)) |=> int1_i);

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_i & en_i)) |=> !int0_i && !int1_i);

  a_r10_pin_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[N_GPIO-1:0] & ~gpio_ie_i) == '0);
endmodule

bind steer_irq_ctrl sic_chk #(.N_SRC(N_SRC), .N_GPIO(N_GPIO)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .en_i      (en),
  .steer_i   (steer),
  .status_i  (status),
  .gpio_ie_i (gpio_ie),
  .int0_i    (int0_o),
  .int1_i    (int1_o)
);

// File: tb/steer_irq_ctrl_tb_top.sv
module steer_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        int0, int1;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  steer_irq_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (irq),
    .req_i (req), .we_i (we), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .int0_o (int0), .int1_o (int1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 int0", {31'd0, int0}, 32'd0);
    check("R1 int1", {31'd0, int1}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      check("R1 reg", d, 32'd0);
    end
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(4'd2, 32'h0000_00F0); rd(4'd1, d); check("R2 set", d, 32'h0000_00F0);
    wr(4'd2, 32'h0000_0F00); rd(4'd1, d); check("R2 zero bits keep", d, 32'h0000_0FF0);
    wr(4'd3, 32'h0000_0030); rd(4'd1, d); check("R3 clear", d, 32'h0000_0FC0);
  endtask

  task automatic t_level_steer();
    logic [31:0] d;
    @(negedge clk); irq[7] = 1'b1;
    idle(1);
    check("R5 sync delay", {31'd0, int0}, 32'd0);
    idle(3);
    rd(4'd0, d); check("R5 level status", d, 32'h80);
    check("R8 int0 on steer 0", {31'd0, int0}, 32'd1);
    check("R8 int1 idle", {31'd0, int1}, 32'd0);
    wr(4'd6, 32'h80); rd(4'd6, d); check("R8 steer readback", d, 32'h80);
    idle(1);
    check("R8 int1 on steer 1", {30'd0, int1, int0}, 32'd2);
    @(negedge clk); irq[7] = 1'b0;
    idle(4);
    rd(4'd0, d); check("R5 level drop", d, 32'h0);
    check("R9 outputs idle", {30'd0, int1, int0}, 32'd0);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(4'd4, 32'h40); idle(4);
    rd(4'd0, d); check("R4 inverted low active", d, 32'h40);
    check("R4 int0", {31'd0, int0}, 32'd1);
    @(negedge clk); irq[6] = 1'b1; idle(4);
    rd(4'd0, d); check("R4 inverted high idle", d, 32'h0);
    check("R4 int0 low", {31'd0, int0}, 32'd0);
    wr(4'd4, 32'h0); @(negedge clk); irq[6] = 1'b0; idle(4);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    @(negedge clk); irq[12] = 1'b1; idle(4);
    rd(4'd0, d); check("R9 status of disabled source", d, 32'h1000);
    check("R9 disabled no output", {30'd0, int1, int0}, 32'd0);
    @(negedge clk); irq[12] = 1'b0; idle(4);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'd5, 32'h100); wr(4'd6, 32'h100);
    @(negedge clk); irq[8] = 1'b1; idle(6);
    @(negedge clk); irq[8] = 1'b0; idle(4);
    rd(4'd0, d); check("R6 latched after fall", d, 32'h100);
    check("R6 int1 from edge", {30'd0, int1, int0}, 32'd2);
    wr(4'd0, 32'h0); rd(4'd0, d); check("R6 zero write keeps", d, 32'h100);
    wr(4'd0, 32'h100); idle(1);
    rd(4'd0, d); check("R6 w1c clears", d, 32'h0);
    check("R6 int1 drops", {30'd0, int1, int0}, 32'd0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk); irq[8] = 1'b1;
    @(negedge clk);
    wr(4'd0, 32'h100);   // lands on the clock edge where the new edge latches
    rd(4'd0, d); check("R7 edge beats clear", d, 32'h100);
    @(negedge clk); irq[8] = 1'b0; idle(4);
    wr(4'd0, 32'h100);
    rd(4'd0, d); check("R7 later clear", d, 32'h0);
    wr(4'd5, 32'h0); wr(4'd6, 32'h0);
  endtask

  task automatic t_gpio();
    logic [31:0] d;
    @(negedge clk); irq[1] = 1'b1; idle(4);
    rd(4'd0, d); check("R10 pin gated", d, 32'h0);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); check("R10 ie width", d, 32'hF);
    idle(1);
    rd(4'd0, d); check("R10 pin enabled", d, 32'h2);
    wr(4'd7, 32'h0); idle(1);
    rd(4'd0, d); check("R10 pin regated", d, 32'h0);
    @(negedge clk); irq[1] = 1'b0; idle(4);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(4'd9, d);  check("R11 unmapped 9", d, 32'h0);
    rd(4'd15, d); check("R11 unmapped 15", d, 32'h0);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 4'd1;
    @(negedge clk); req = 1'b0;
    check("R11 one cycle latency", rdata, 32'h0000_0FC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_enable();
    t_level_steer();
    t_polarity();
    t_mask();
    t_edge();
    t_race();
    t_gpio();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule